// File: doc/BRIEF.md
# I2S Audio Serial Receiver

This block is the receive channel of an I2S audio port. It watches a serial bit clock, a word-select line and a serial data line, all sampled into the system clock domain. It shifts in bits MSB first on each rising bit-clock edge, closes a word each time word select changes, and tags the word as left (word select low) or right (word select high). Completed words go into a receive FIFO that holds 8 bytes. Each entry is 8, 16 or 32 bits wide, set by the selected sample width.

Word select can come from a pin (slave) or from an internal counter that toggles after a programmable number of bit-clock edges (master). In mono mode only the left-phase word of each frame is kept, because the right phase repeats it. A stop input keeps completed words out of the FIFO. The mute input has no effect on reception. A word that completes while the FIFO has no room is dropped, and a sticky overrun flag is set.

Top module: `i2s_rx`

## Requirements
- R1: After reset the FIFO is empty, level_o is 0, ovr_o is 0 and ws_o is 0.
- R2: A rising bit-clock edge that sees word select different from the previous edge closes the current word. The bit sampled on that edge is the word's LSB. Bits are MSB first, and the word is tagged rd_right_o=0 if word select was low during it and rd_right_o=1 if it was high.
- R3: width_i selects the sample width: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 give 32 bits. The word is returned in rd_data_o[W-1:0], with the upper bits zero.
- R4: A word shorter than the width is left-aligned in the W-bit field, and its missing low bits are zero.
- R5: In a word longer than the width, only the first W bits are kept and later bits are ignored.
- R6: With mono_i=1, only words tagged left are written to the FIFO. Right-phase words are discarded.
- R7: With master_i=1, ws_o toggles once every half_i+1 rising bit-clock edges, and that signal delimits the words.
- R8: While stop_i=1, no word is written and ovr_o is cleared. Writing resumes once stop_i returns to 0.
- R9: mute_i does not change which words are captured or their values.
- R10: level_o reports the stored bytes (words × W/8). The FIFO holds 8, 4 or 2 words at widths 8, 16 or 32.
- R11: A word that completes when the FIFO is full and no pop occurs is dropped. ovr_o is then set and stays set until reset or stop_i.
- R12: A pop and a completed word in the same cycle on a full FIFO both take effect, and no overrun is flagged.
- R13: rd_i pops the oldest word, and rd_data_o/rd_right_o show the head word. rd_i on an empty FIFO is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1: internal word-select counter; 0: word select from ws_i |
| half_i | input | 9 | Half-period of the internal word select, minus one, in bit clocks |
| width_i | input | 2 | Sample width code: 0=8, 1=16, 2/3=32 bits |
| mono_i | input | 1 | Keep only the left-phase words |
| stop_i | input | 1 | Block FIFO writes and clear overrun |
| mute_i | input | 1 | Transmit-side mute; no effect on reception |
| sck_i | input | 1 | Serial bit clock |
| ws_i | input | 1 | Word select from pin (slave) |
| sd_i | input | 1 | Serial data, MSB first |
| ws_o | output | 1 | Internally generated word select |
| rd_i | input | 1 | Pop the head word |
| rd_data_o | output | 32 | Head word data |
| rd_right_o | output | 1 | Head word channel tag: 0 left, 1 right |
| empty_o | output | 1 | FIFO holds no word |
| level_o | output | 4 | Bytes stored |
| ovr_o | output | 1 | Sticky overrun flag |

## Verification
A pop from the FIFO and a word completing on the write side can land in the same system-clock cycle while the FIFO is full. The bench fills the FIFO at 16-bit width. It then pulses rd_i for exactly the cycle in which the next word's LSB edge reaches the write port, counting the synchronizer and shifter registers from the driven bit-clock rise. The case passes if level stays at 8 bytes, the overrun flag stays clear, and the remaining words come out in order, ending with the new one.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;

  localparam int unsigned MAX_W = 32;

  typedef struct packed {
    logic              right;
    logic [MAX_W-1:0]  data;
  } rx_word_t;

  function automatic logic [5:0] wid_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 6'd8;
      2'd1:    return 6'd16;
      default: return 6'd32;
    endcase
  endfunction

  function automatic logic [2:0] wid_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/i2s_rx_sync.sv
module i2s_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic ws_i,
  input  logic sd_i,
  output logic bit_stb_o,
  output logic ws_o,
  output logic sd_o
);
  logic [STAGES-1:0] sck_q, ws_q, sd_q;
  logic              sck_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= '0;
      ws_q  <= '0;
      sd_q  <= '0;
      sck_d <= 1'b0;
    end else begin
      sck_q <= {sck_q[STAGES-2:0], sck_i};
      ws_q  <= {ws_q[STAGES-2:0], ws_i};
      sd_q  <= {sd_q[STAGES-2:0], sd_i};
      sck_d <= sck_q[STAGES-1];
    end
  end

  // rising bit-clock edge, data and word select aligned to it
  assign bit_stb_o = sck_q[STAGES-1] & ~sck_d;
  assign ws_o      = ws_q[STAGES-1];
  assign sd_o      = sd_q[STAGES-1];

endmodule

// File: rtl/i2s_rx_wsgen.sv
module i2s_rx_wsgen #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_stb_i,
  input  logic [CNT_W-1:0] half_i,
  output logic             ws_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ws_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ws_q  <= 1'b0;
    end else if (bit_stb_i) begin
      if (cnt_q >= half_i) begin
        cnt_q <= '0;
        ws_q  <= ~ws_q;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign ws_o = ws_q;

  // R7
  ws_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ws_q != $past(ws_q)) |-> ($past(bit_stb_i) && ($past(cnt_q) >= $past(half_i))));

endmodule

// File: rtl/i2s_rx_shift.sv
module i2s_rx_shift
  import i2s_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_stb_i,
  input  logic       ws_i,
  input  logic       sd_i,
  input  logic [1:0] width_i,
  input  logic       mono_i,
  output logic       word_vld_o,
  output rx_word_t   word_o
);
  logic             ws_known_q, in_word_q, ws_prev_q, vld_q;
  logic [5:0]       bit_cnt_q, cnt_nx, wbits;
  logic [MAX_W-1:0] sh_q, sh_nx, data_al;
  logic             take, ws_edge, emit;
  rx_word_t         word_q;

  assign wbits = wid_bits(width_i);

  always_comb begin
    take    = bit_cnt_q < wbits;   // surplus bits dropped
    sh_nx   = take ? {sh_q[MAX_W-2:0], sd_i} : sh_q;
    cnt_nx  = take ? bit_cnt_q + 6'd1 : bit_cnt_q;
    ws_edge = ws_known_q && (ws_i != ws_prev_q);
    emit    = bit_stb_i && ws_edge && in_word_q && !(mono_i && ws_prev_q);
    data_al = sh_nx << (wbits - cnt_nx);   // zero-fill short words
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ws_known_q <= 1'b0;
      in_word_q  <= 1'b0;
      ws_prev_q  <= 1'b0;
      bit_cnt_q  <= '0;
      sh_q       <= '0;
      vld_q      <= 1'b0;
      word_q     <= '0;
    end else begin
      vld_q <= emit;
      if (emit) word_q <= '{right: ws_prev_q, data: data_al};
      if (bit_stb_i) begin
        if (!ws_known_q) begin
          ws_known_q <= 1'b1;
          ws_prev_q  <= ws_i;
        end else if (ws_edge) begin
          ws_prev_q <= ws_i;
          in_word_q <= 1'b1;
          bit_cnt_q <= '0;
          sh_q      <= '0;
        end else begin
          bit_cnt_q <= cnt_nx;
          sh_q      <= sh_nx;
        end
      end
    end
  end

  assign word_vld_o = vld_q;
  assign word_o     = word_q;

  // R5
  bit_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_q <= wid_bits(width_i));

  // R2
  word_after_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> ($past(bit_stb_i) && bit_cnt_q == 6'd0));

endmodule

// File: rtl/i2s_rx_fifo.sv
module i2s_rx_fifo
  import i2s_rx_pkg::*;
#(
  parameter int unsigned DEPTH_BYTES = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH_BYTES),
  localparam int unsigned LVL_W = $clog2(DEPTH_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  rx_word_t         word_i,
  input  logic             stop_i,
  input  logic [1:0]       width_i,
  input  logic             rd_i,
  output rx_word_t         head_o,
  output logic             empty_o,
  output logic [LVL_W-1:0] level_o,
  output logic             ovr_o
);
  // one slot per byte covers the narrowest width; depth is a power of two
  rx_word_t         mem [DEPTH_BYTES];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [LVL_W-1:0] cnt_q;
  logic             ovr_q, do_rd, do_wr, space;
  logic [2:0]       bpw;
  int               used_after;

  always_comb begin
    bpw        = wid_bytes(width_i);
    do_rd      = rd_i && (cnt_q != '0);
    used_after = (int'(cnt_q) - int'(do_rd) + 1) * int'(bpw);
    space      = used_after <= int'(DEPTH_BYTES);
    do_wr      = wr_i && !stop_i && space;
  end

  always_ff @(posedge clk_i) begin
    if (do_wr) mem[wp_q] <= word_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      if (do_wr) wp_q <= wp_q + PTR_W'(1);
      if (do_rd) rp_q <= rp_q + PTR_W'(1);
      cnt_q <= cnt_q + LVL_W'(do_wr) - LVL_W'(do_rd);
      if (stop_i)                 ovr_q <= 1'b0;
      else if (wr_i && !space)    ovr_q <= 1'b1;
    end
  end

  assign head_o  = mem[rp_q];
  assign empty_o = cnt_q == '0;
  assign level_o = LVL_W'(int'(cnt_q) * int'(bpw));
  assign ovr_o   = ovr_q;

  // R10
  level_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(level_o) <= int'(DEPTH_BYTES));

  // R11
  drop_on_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !stop_i && !rd_i && !space) |=> (ovr_o && $stable(cnt_q)));

  // R13
  empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && empty_o && !wr_i) |=> (empty_o && $stable(rp_q)));

endmodule

// File: rtl/i2s_rx.sv
module i2s_rx
  import i2s_rx_pkg::*;
#(
  parameter int unsigned WS_CNT_W    = 9,
  parameter int unsigned DEPTH_BYTES = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               master_i,
  input  logic [WS_CNT_W-1:0]                half_i,
  input  logic [1:0]                         width_i,
  input  logic                               mono_i,
  input  logic                               stop_i,
  input  logic                               mute_i,
  input  logic                               sck_i,
  input  logic                               ws_i,
  input  logic                               sd_i,
  output logic                               ws_o,
  input  logic                               rd_i,
  output logic [31:0]                        rd_data_o,
  output logic                               rd_right_o,
  output logic                               empty_o,
  output logic [$clog2(DEPTH_BYTES+1)-1:0]   level_o,
  output logic                               ovr_o
);
  logic     bit_stb, ws_pin, sd_s, ws_gen, ws_eff, word_vld;
  rx_word_t word, head;

  i2s_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sck_i, .ws_i, .sd_i,
    .bit_stb_o(bit_stb), .ws_o(ws_pin), .sd_o(sd_s)
  );

  i2s_rx_wsgen #(.CNT_W(WS_CNT_W)) u_wsgen (
    .clk_i, .rst_ni, .bit_stb_i(bit_stb), .half_i, .ws_o(ws_gen)
  );

  assign ws_eff = master_i ? ws_gen : ws_pin;

  i2s_rx_shift u_shift (
    .clk_i, .rst_ni, .bit_stb_i(bit_stb), .ws_i(ws_eff), .sd_i(sd_s),
    .width_i, .mono_i, .word_vld_o(word_vld), .word_o(word)
  );

  i2s_rx_fifo #(.DEPTH_BYTES(DEPTH_BYTES)) u_fifo (
    .clk_i, .rst_ni, .wr_i(word_vld), .word_i(word), .stop_i, .width_i,
    .rd_i, .head_o(head), .empty_o, .level_o, .ovr_o
  );

  assign ws_o       = ws_gen;
  assign rd_data_o  = head.data;
  assign rd_right_o = head.right;

  // R8
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !rd_i) |=> $stable(level_o));

  // R9
  mute_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mute_i && word_vld && !stop_i && !rd_i && empty_o) |=> !empty_o);

  // R6
  mono_left_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mono_i && word_vld && !stop_i && !rd_i && empty_o) |=> !rd_right_o);

endmodule

// File: tb/sim_i2s_rx.sv
`timescale 1ns/1ps
module sim_i2s_rx;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        master_i = 1'b0;
  logic [8:0]  half_i = 9'd7;
  logic [1:0]  width_i = 2'd1;
  logic        mono_i = 1'b0, stop_i = 1'b0, mute_i = 1'b0;
  logic        sck_i = 1'b0, ws_i = 1'b1, sd_i = 1'b0;
  logic        rd_i = 1'b0;
  logic        ws_o, rd_right_o, empty_o, ovr_o;
  logic [31:0] rd_data_o;
  logic [3:0]  level_o;
  int          checks = 0, errors = 0;

  i2s_rx u0 (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic tx_bit(input logic w, input logic d, input logic rdp);
    @(negedge clk_i);
    sck_i = 1'b0; ws_i = w; sd_i = d;
    repeat (4) @(negedge clk_i);
    sck_i = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk_i);
      rd_i = (rdp && k == 3);  // pop lands on the write cycle
    end
  endtask

  task automatic tx_word(input logic ch, input logic [31:0] d, input int n,
                         input logic nxt, input logic rdp = 1'b0);
    for (int i = n - 1; i >= 0; i--)
      tx_bit(i == 0 ? nxt : ch, d[i], (i == 0) && rdp);
  endtask

  task automatic drain();
    @(negedge clk_i);
    while (!empty_o) begin
      rd_i = 1'b1; @(negedge clk_i);
      rd_i = 1'b0; @(negedge clk_i);
    end
  endtask

  task automatic sync_ws();
    tx_bit(1'b1, 1'b0, 1'b0);
    tx_bit(1'b1, 1'b0, 1'b0);
    tx_bit(1'b0, 1'b0, 1'b0);
    drain();
  endtask

  task automatic pop(input string req, input logic [31:0] d, input logic r);
    @(negedge clk_i);
    chk({req, " nonempty"}, {31'd0, empty_o}, 32'd0);
    chk({req, " data"}, rd_data_o, d);
    chk({req, " tag"}, {31'd0, rd_right_o}, {31'd0, r});
    rd_i = 1'b1; @(negedge clk_i); rd_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 empty", {31'd0, empty_o}, 32'd1);
    chk("R1 level", {28'd0, level_o}, 32'd0);
    chk("R1 ovr", {31'd0, ovr_o}, 32'd0);
    chk("R1 ws_o", {31'd0, ws_o}, 32'd0);
  endtask

  task automatic t_stereo16();
    width_i = 2'd1; sync_ws();
    tx_word(1'b0, 32'h1234, 16, 1'b1);
    tx_word(1'b1, 32'hBEEF, 16, 1'b0);
    chk("R10 level 16b", {28'd0, level_o}, 32'd4);
    pop("R2 left", 32'h1234, 1'b0);
    pop("R2 right", 32'hBEEF, 1'b1);
    rd_i = 1'b1; @(negedge clk_i); rd_i = 1'b0; @(negedge clk_i);
    chk("R13 empty pop ignored", {27'd0, empty_o, level_o}, 32'h10);
  endtask

  task automatic t_widths();
    width_i = 2'd0; sync_ws();
    tx_word(1'b0, 32'hA5, 8, 1'b1);
    tx_word(1'b1, 32'h3C, 8, 1'b0);
    pop("R3 8b", 32'hA5, 1'b0);
    pop("R3 8b", 32'h3C, 1'b1);
    width_i = 2'd2; sync_ws();
    tx_word(1'b0, 32'hDEADBEEF, 32, 1'b1);
    tx_word(1'b1, 32'h01234567, 32, 1'b0);
    chk("R10 level 32b", {28'd0, level_o}, 32'd8);
    pop("R3 32b", 32'hDEADBEEF, 1'b0);
    pop("R3 32b", 32'h01234567, 1'b1);
  endtask

  task automatic t_short_long();
    width_i = 2'd0; sync_ws();
    tx_word(1'b0, 32'h16, 5, 1'b1);    // 10110
    tx_word(1'b1, 32'hABC, 12, 1'b0);
    pop("R4 zero fill", 32'hB0, 1'b0);
    pop("R5 surplus ignored", 32'hAB, 1'b1);
  endtask

  task automatic t_mono();
    width_i = 2'd1; mono_i = 1'b1; sync_ws();
    tx_word(1'b0, 32'h1234, 16, 1'b1);
    tx_word(1'b1, 32'h1234, 16, 1'b0);
    tx_word(1'b0, 32'hBEEF, 16, 1'b1);
    tx_word(1'b1, 32'hBEEF, 16, 1'b0);
    chk("R6 mono level", {28'd0, level_o}, 32'd4);
    pop("R6 mono", 32'h1234, 1'b0);
    pop("R6 mono", 32'hBEEF, 1'b0);
    mono_i = 1'b0;
  endtask

  task automatic t_mute();
    width_i = 2'd1; mute_i = 1'b1; sync_ws();
    tx_word(1'b0, 32'hA55A, 16, 1'b1);
    tx_word(1'b1, 32'h5AA5, 16, 1'b0);
    pop("R9 mute", 32'hA55A, 1'b0);
    pop("R9 mute", 32'h5AA5, 1'b1);
    mute_i = 1'b0;
  endtask

  task automatic t_master();
    int   last, nchg;
    logic prev, tag_prev;
    width_i = 2'd0; half_i = 9'd7; master_i = 1'b1;
    for (int i = 0; i < 20; i++) tx_bit(1'b0, 1'b1, 1'b0);
    drain();
    prev = ws_o; last = -1; nchg = 0;
    for (int i = 0; i < 32; i++) begin
      tx_bit(1'b0, 1'b1, 1'b0);
      if (ws_o != prev) begin
        if (last >= 0) chk("R7 ws period", i - last, 32'd8);
        last = i; nchg++; prev = ws_o;
      end
    end
    chk("R7 toggles", nchg, 32'd4);
    chk("R7 words", {28'd0, level_o}, 32'd4);
    tag_prev = ~rd_right_o;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      chk("R7 master data", rd_data_o, 32'hFF);
      chk("R7 tag alternates", {31'd0, rd_right_o}, {31'd0, ~tag_prev});
      tag_prev = rd_right_o;
      rd_i = 1'b1; @(negedge clk_i); rd_i = 1'b0;
    end
    master_i = 1'b0;
  endtask

  task automatic t_same_cycle();
    width_i = 2'd1; sync_ws();
    tx_word(1'b0, 32'h1111, 16, 1'b1);
    tx_word(1'b1, 32'h2222, 16, 1'b0);
    tx_word(1'b0, 32'h3333, 16, 1'b1);
    tx_word(1'b1, 32'h4444, 16, 1'b0);
    chk("R10 full 16b", {28'd0, level_o}, 32'd8);
    tx_word(1'b0, 32'h5555, 16, 1'b1, 1'b1);
    chk("R12 level", {28'd0, level_o}, 32'd8);
    chk("R12 no overrun", {31'd0, ovr_o}, 32'd0);
    pop("R12 order", 32'h2222, 1'b1);
    pop("R12 order", 32'h3333, 1'b0);
    pop("R12 order", 32'h4444, 1'b1);
    pop("R12 new word", 32'h5555, 1'b0);
  endtask

  task automatic t_overrun();
    logic ch;
    width_i = 2'd0; sync_ws(); ch = 1'b0;
    for (int i = 1; i <= 9; i++) begin
      tx_word(ch, 32'h11 * i, 8, ~ch);
      ch = ~ch;
    end
    chk("R11 level", {28'd0, level_o}, 32'd8);
    chk("R11 ovr set", {31'd0, ovr_o}, 32'd1);
    for (int i = 1; i <= 8; i++) pop("R11 kept", 32'h11 * i, (i % 2) == 0);
    chk("R11 ovr sticky", {31'd0, ovr_o}, 32'd1);
  endtask

  task automatic t_stop();
    width_i = 2'd0; stop_i = 1'b1;
    @(negedge clk_i);
    chk("R8 ovr cleared", {31'd0, ovr_o}, 32'd0);
    sync_ws();
    tx_word(1'b0, 32'h5A, 8, 1'b1);
    tx_word(1'b1, 32'hC3, 8, 1'b0);
    chk("R8 no write", {27'd0, empty_o, level_o}, 32'h10);
    stop_i = 1'b0;
    tx_word(1'b0, 32'h69, 8, 1'b1);
    tx_word(1'b1, 32'h96, 8, 1'b0);
    pop("R8 resume", 32'h69, 1'b0);
    pop("R8 resume", 32'h96, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_stereo16();
    t_widths();
    t_short_long();
    t_mono();
    t_mute();
    t_master();
    t_same_cycle();
    t_overrun();
    t_stop();
    summary();
  end

endmodule